// File: doc/BRIEF.md
# Voltage Code Ramp Controller

This block owns the 8-bit output voltage code of one switching regulator channel. Rather than jumping to a newly programmed value, the code walks toward its target one code LSB at a time. The time between steps is one of four binary-scaled intervals. A step lasts 8, 4, 2 or 1 microsecond ticks. A parameterised prescaler turns the system clock into that microsecond tick.

Two targets and two operating modes are held: one pair for the run power state and one pair for standby. A power-state input picks which pair is live. A mode can be off, PWM or PFM. While the live mode is off, the code freezes and the channel enable drops. Software programs the block through a plain address/data/write-strobe port. The outputs are the current code, the live mode, a channel enable and a ramp-busy flag. Analog conversion and the mapping from code to volts are handled elsewhere.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: Registers are written on a rising clock edge while `wr_en` is high. The addresses are: 0 = run target, 1 = standby target, 2 = mode, 3 = config. A synchronous reset clears every register. Reset also sets the code to 0, `en_out` to 0, `mode_out` to 00 and `busy_out` to 0.
- R2: While `stby` is high, the standby target and the standby mode are live; otherwise the run target and the run mode are live. A change of `stby` takes effect at the next clock edge.
- R3: In the mode register, bits 1:0 hold the run mode and bits 3:2 hold the standby mode, with the encoding 00 off, 01 PWM and 10 PFM (11 acts as off). `mode_out` shows the live mode field. `en_out` is high exactly when that field is PWM or PFM.
- R4: Config bits 4:3 choose the step interval: 00 is 8 ticks, 01 is 4 ticks, 10 is 2 ticks and 11 is 1 tick. One tick lasts `TICK_DIV` clock cycles, so a step period P is (ticks × `TICK_DIV`) cycles.
- R5: Each step moves the code by exactly one LSB toward the live target. The code never passes the target and stays still once it equals the target.
- R6: A register write at edge k takes effect as the live selection at edge k+1. When this starts a ramp, the first step lands at edge k+1+P, and each further step lands P cycles after the one before.
- R7: If the live target changes during a ramp, stepping continues from the present code on the same step schedule, with no jump. It reverses direction if the new target lies behind the code.
- R8: While the live mode is off, the code holds, `en_out` is low and no steps occur. When a mode turns on at edge t, the first step lands at edge t+P.
- R9: `busy_out` is high exactly when the code differs from the live target, whatever the mode.
- R10: Writes to the registers of the power state that is not live leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CODE_W | Register write data |
| stby | input | 1 | Standby power state select |
| code_out | output | CODE_W | Current voltage code |
| mode_out | output | 2 | Live mode field |
| en_out | output | 1 | Channel enable (live mode is PWM or PFM) |
| busy_out | output | 1 | Code differs from the live target |

## Verification
The bench checks each code change against the value and the exact clock cycle predicted from the step period. This catches a design that starts the first step early or late. It also catches a design that restarts its timer when the target moves. The bench reverses the target halfway through a ramp. A design that jumped, or overshot before turning back, would produce a wrong code sequence. It also tries the slowest rate, swaps to standby and back, and programs a new target while the mode is off. A design that kept stepping while off, or that leaked writes to standby registers into the run outputs, would show an unexpected code change.

// File: rtl/dvs_pkg.sv
`timescale 1ns/1ps
package dvs_pkg;
  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_TGT_RUN  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_TGT_STBY = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE     = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CFG      = 2'd3;

  localparam int RUN_MODE_LSB  = 0;
  localparam int STBY_MODE_LSB = 2;
  localparam int RATE_LSB      = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PWM  = 2'b01,
    MODE_PFM  = 2'b10,
    MODE_RSVD = 2'b11
  } dvs_mode_e;

  function automatic logic mode_is_on(input dvs_mode_e m);
    return (m == MODE_PWM) || (m == MODE_PFM);
  endfunction
endpackage

// File: rtl/dvs_regs.sv
`timescale 1ns/1ps
module dvs_regs
  import dvs_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0]     wr_data,
  input  logic                  stby,
  output logic [CODE_W-1:0]     act_tgt,
  output dvs_mode_e             act_mode,
  output logic [1:0]            rate
);
  logic [CODE_W-1:0] tgt_run;
  logic [CODE_W-1:0] tgt_stby;
  logic [1:0]        mode_run;
  logic [1:0]        mode_stby;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_run   <= '0;
      tgt_stby  <= '0;
      mode_run  <= '0;
      mode_stby <= '0;
      rate      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_TGT_RUN:  tgt_run  <= wr_data;
        ADDR_TGT_STBY: tgt_stby <= wr_data;
        ADDR_MODE: begin
          mode_run  <= wr_data[RUN_MODE_LSB +: 2];
          mode_stby <= wr_data[STBY_MODE_LSB +: 2];
        end
        default:       rate <= wr_data[RATE_LSB +: 2];
      endcase
    end
  end

  // live selection registered once, so the ramp logic sees a clean source
  always_ff @(posedge clk) begin
    if (rst) begin
      act_tgt  <= '0;
      act_mode <= MODE_OFF;
    end else begin
      act_tgt  <= stby ? tgt_stby : tgt_run;
      act_mode <= dvs_mode_e'(stby ? mode_stby : mode_run);
    end
  end

  AST_RUN_TGT_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_TGT_RUN) |=> (tgt_run == $past(wr_data))); // R1
  AST_STBY_SELECT: assert property (@(posedge clk) disable iff (rst)
    ($past(stby) && !$past(wr_en)) |-> (act_tgt == tgt_stby)); // R2
endmodule

// File: rtl/dvs_step_timer.sv
`timescale 1ns/1ps
module dvs_step_timer #(
  parameter int TICK_DIV = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       step
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SC_W  = 4;

  logic            tick;
  logic [SC_W-1:0] lim;
  logic [SC_W-1:0] scnt;

  generate
    if (TICK_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || !run)                     pre <= '0;
        else if (pre == PRE_W'(TICK_DIV-1))  pre <= '0;
        else                                 pre <= pre + 1'b1;
      end
      assign tick = run && (pre == PRE_W'(TICK_DIV-1));

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre <= PRE_W'(TICK_DIV-1)); // R4
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  assign lim = 4'd8 >> rate;

  always_ff @(posedge clk) begin
    if (rst || !run)  scnt <= '0;
    else if (tick)    scnt <= (scnt >= lim - 4'd1) ? '0 : scnt + 1'b1;
  end

  assign step = tick && (scnt >= lim - 4'd1);

  AST_TICK_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    scnt < 4'd8); // R4
endmodule

// File: rtl/dvs_code_stepper.sv
`timescale 1ns/1ps
module dvs_code_stepper #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst)       code <= '0;
    else if (step) code <= (code < tgt) ? code + 1'b1 : code - 1'b1;
  end

  AST_ONE_LSB: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |->
      (code == CODE_W'($past(code) + 1'b1) || code == CODE_W'($past(code) - 1'b1))); // R5
  AST_UP_TOWARD: assert property (@(posedge clk) disable iff (rst)
    (code > $past(code)) |-> ($past(tgt) > $past(code))); // R7
  AST_DOWN_TOWARD: assert property (@(posedge clk) disable iff (rst)
    (code < $past(code)) |-> ($past(tgt) < $past(code))); // R7
endmodule

// File: rtl/dvs_ramp_ctrl.sv
`timescale 1ns/1ps
module dvs_ramp_ctrl
  import dvs_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int TICK_DIV = 200
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0]     wr_data,
  input  logic                  stby,
  output logic [CODE_W-1:0]     code_out,
  output logic [1:0]            mode_out,
  output logic                  en_out,
  output logic                  busy_out
);
  logic [CODE_W-1:0] act_tgt;
  dvs_mode_e         act_mode;
  logic [1:0]        rate;
  logic              act_on;
  logic              busy;
  logic              run;
  logic              step;
  logic [CODE_W-1:0] code;

  dvs_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stby(stby), .act_tgt(act_tgt), .act_mode(act_mode), .rate(rate)
  );

  assign act_on = mode_is_on(act_mode);
  assign busy   = (code != act_tgt);
  assign run    = act_on && busy;

  dvs_step_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk(clk), .rst(rst), .run(run), .rate(rate), .step(step)
  );

  dvs_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst(rst), .step(step), .tgt(act_tgt), .code(code)
  );

  assign code_out = code;
  assign mode_out = act_mode;
  assign en_out   = act_on;
  assign busy_out = busy;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_out |=> (code_out == $past(code_out))); // R8
  AST_REST_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    !busy_out |=> (code_out == $past(code_out))); // R5
endmodule

// File: tb/sim_dvs_ramp_ctrl.sv
`timescale 1ns/1ps
module sim_dvs_ramp_ctrl;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       stby = 1'b0;
  logic [7:0] code_out;
  logic [1:0] mode_out;
  logic       en_out;
  logic       busy_out;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];
  logic [7:0] last_code = '0;
  int    ev, ec;
  string et;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dvs_ramp_ctrl #(.CODE_W(8), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stby(stby), .code_out(code_out), .mode_out(mode_out), .en_out(en_out),
    .busy_out(busy_out)
  );

  // monitor: every code change must match the next scoreboard item in value and cycle
  always @(negedge clk) begin
    if (rst) begin
      last_code = code_out;
    end else if (code_out !== last_code) begin
      n_chk++;
      if (q_val.size() == 0) begin
        n_err++;
        $display("FAIL R5 unexpected code change: actual %0d expected %0d", code_out, last_code);
      end else begin
        ev = q_val.pop_front();
        ec = q_cyc.pop_front();
        et = q_tag.pop_front();
        if (code_out !== ev[7:0] || cyc != ec) begin
          n_err++;
          $display("FAIL %s step: actual code %0d at edge %0d expected code %0d at edge %0d",
                   et, code_out, cyc, ev, ec);
        end
      end
      last_code = code_out;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v, input int c, input string tag);
    q_val.push_back(v);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  // steps land at t0+P, t0+2P, ... where t0 is the edge the selection takes effect
  task automatic expect_ramp(input int from, input int to, input int t0, input int p,
                             input string tag);
    int c = from;
    int n = 0;
    while (c != to) begin
      c = (to > c) ? c + 1 : c - 1;
      n++;
      push(c, t0 + n * p, tag);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int k);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    k = cyc;
  endtask

  task automatic wait_done(input string tag);
    int w = 0;
    while (q_val.size() != 0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (q_val.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL %s ramp stalled: actual %0d steps pending expected 0", tag, q_val.size());
      q_val.delete(); q_cyc.delete(); q_tag.delete();
    end
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int k, k2, s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code", code_out, 0);
    chk("R1 reset enable", en_out, 0);
    chk("R1 reset mode", mode_out, 0);
    chk("R9 reset busy", busy_out, 0);

    // run mode PWM
    wr(2'd2, 8'h01, k);
    @(negedge clk);
    chk("R3 run PWM mode", mode_out, 1);
    chk("R3 run PWM enable", en_out, 1);

    // rate 11 -> P = 1*DIV, ramp up 0 -> 3
    wr(2'd3, 8'h18, k);
    wr(2'd0, 8'd3, k);
    expect_ramp(0, 3, k + 1, 1 * DIV, "R6");
    @(negedge clk);
    chk("R9 busy during ramp", busy_out, 1);
    wait_done("R6");
    chk("R9 busy clear at target", busy_out, 0);

    // rate 00 -> P = 8*DIV
    wr(2'd3, 8'h00, k);
    wr(2'd0, 8'd5, k);
    expect_ramp(3, 5, k + 1, 8 * DIV, "R4");
    wait_done("R4");

    // rate 10 -> P = 2*DIV, ramp down
    wr(2'd3, 8'h10, k);
    wr(2'd0, 8'd2, k);
    expect_ramp(5, 2, k + 1, 2 * DIV, "R5");
    wait_done("R5");
    chk("R5 settled code", code_out, 2);

    // mid-ramp reversal at rate 11
    wr(2'd3, 8'h18, k);
    wr(2'd0, 8'd10, k);
    push(3, k + 1 + DIV, "R7");
    push(4, k + 1 + 2 * DIV, "R7");
    push(5, k + 1 + 3 * DIV, "R7");
    push(4, k + 1 + 4 * DIV, "R7");
    push(3, k + 1 + 5 * DIV, "R7");
    while (cyc != k + 3 * DIV + 1) @(negedge clk);
    wr(2'd0, 8'd3, k2);
    wait_done("R7");
    chk("R7 reversed to new target", code_out, 3);
    chk("R9 idle after reversal", busy_out, 0);

    // inactive-state writes: standby target and standby mode while in run
    wr(2'd1, 8'd8, k);
    wr(2'd2, 8'h09, k);
    repeat (3 * DIV) @(negedge clk);
    chk("R10 code unchanged", code_out, 3);
    chk("R10 mode unchanged", mode_out, 1);
    chk("R10 busy unchanged", busy_out, 0);

    // enter standby: target 8, mode PFM
    @(negedge clk);
    stby = 1'b1;
    s = cyc + 1;
    expect_ramp(3, 8, s, DIV, "R2");
    @(negedge clk);
    chk("R3 standby PFM mode", mode_out, 2);
    chk("R2 standby busy", busy_out, 1);
    wait_done("R2");

    // back to run
    @(negedge clk);
    stby = 1'b0;
    s = cyc + 1;
    expect_ramp(8, 3, s, DIV, "R2");
    @(negedge clk);
    chk("R2 run mode restored", mode_out, 1);
    wait_done("R2");

    // off: target change must not move the code
    wr(2'd2, 8'h00, k);
    @(negedge clk);
    chk("R8 off enable low", en_out, 0);
    chk("R3 off mode", mode_out, 0);
    wr(2'd0, 8'd6, k);
    repeat (40) @(negedge clk);
    chk("R8 code held while off", code_out, 3);
    chk("R9 busy while off", busy_out, 1);

    // turn on as PFM; ramp resumes a full period later
    wr(2'd2, 8'h02, k);
    expect_ramp(3, 6, k + 1, DIV, "R8");
    @(negedge clk);
    chk("R8 enable after resume", en_out, 1);
    chk("R3 run PFM mode", mode_out, 2);
    wait_done("R8");
    chk("R8 final code", code_out, 6);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule